// File: doc/BRIEF.md
# Battery Temperature Window Qualifier

This block turns four digitised thermistor comparator flags into one filtered "temperature valid" signal. The charge sequencer reads that signal and pauses charging while it is low. An invalid temperature is treated as a suspend condition, not as a fault. The block does not latch invalid temperature as an error, and charging resumes once the window is qualified again.

The filtering is asymmetric. When the output is valid, an out-of-range reading must persist for a long interval, `OUT_MS` ticks (400 by default), before the output drops. When the output is invalid, an in-range reading must persist for a short interval, `IN_MS` ticks (20 by default), before the output rises.

The cold side has hysteresis through a separate release flag. A pack that has been too cold only counts as back in range once the divider voltage is below the lower cold-release level. Being merely below the cold trip level is not enough. All counting advances only on cycles where the one-millisecond tick enable is high.

Top module: `temp_window_qual`

## Requirements
- R1: While `tempValid` is 1, the reading is out of range when any of `coldTrip`, `hotTrip` or `cutTrip` is 1. `tempValid` falls at the clock edge of the `OUT_MS`-th consecutive tick on which the reading is out of range.
- R2: While `tempValid` is 0, the reading is in range only when `coldRelease` is 1 and `coldTrip`, `hotTrip` and `cutTrip` are all 0. `tempValid` rises at the clock edge of the `IN_MS`-th consecutive tick on which the reading is in range.
- R3: Cold hysteresis band. While `tempValid` is 0, a reading with `coldTrip`=0 and `coldRelease`=0 does not count toward resuming. A cold-release reading together with `hotTrip`=1 also does not count.
- R4: Any cycle on which the active condition is absent clears the count. A later qualification therefore needs the full interval again, and the output does not change.
- R5: Reset, asynchronous and active low, forces `tempValid` to 0 and clears the count. The first assertion of `tempValid` then needs `IN_MS` in-range ticks.
- R6: `tempValid` changes only on the clock edge of a cycle with `msTick`=1. Clock cycles without a tick leave the output and the count unchanged.
- R7: The tick counter saturates instead of wrapping. It never exceeds `OUT_MS`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse every millisecond; count enable |
| coldTrip | input | 1 | Divider voltage above the cold trip level |
| coldRelease | input | 1 | Divider voltage below the cold release level (cold trip minus hysteresis) |
| hotTrip | input | 1 | Divider voltage below the hot trip level |
| cutTrip | input | 1 | Divider voltage below the cutoff level |
| tempValid | output | 1 | Filtered temperature valid; 0 suspends charging |

## Verification
The bench builds the block with `OUT_MS`=12 and `IN_MS`=4, with a tick every four clocks. At these values, the last tick short of either interval and the tick that completes it can each be checked within a few dozen clocks. The hot, cutoff and cold exits, the hysteresis band, and an interruption one tick before a threshold all fit in a single table walk. The long-interval limit stays larger than the short one, so a wrong interval choice after a state change shows up as an early or late transition.

// File: rtl/temp_window_qual_pkg.sv
package temp_window_qual_pkg;
  // Strobes from control to the interval counter datapath.
  typedef struct packed {
    logic clrCnt;   // restart the interval
    logic incCnt;   // one qualified tick
    logic selLong;  // compare against the long (leave-window) interval
  } qualStrobes_t;
endpackage

// File: rtl/temp_window_qual_dp.sv
module temp_window_qual_dp
  import temp_window_qual_pkg::*;
#(
  parameter int OUT_MS = 400,
  parameter int IN_MS  = 20,
  localparam int MAX_MS = (OUT_MS > IN_MS) ? OUT_MS : IN_MS,
  localparam int CNT_W  = $clog2(MAX_MS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qualStrobes_t     strobes,
  output logic [CNT_W-1:0] cnt,
  output logic             atLimit
);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(OUT_MS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(IN_MS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = LONG_LAST > SHORT_LAST ? LONG_LAST : SHORT_LAST;

  logic [CNT_W-1:0] lastVal;

  assign lastVal = strobes.selLong ? LONG_LAST : SHORT_LAST;
  assign atLimit = (cnt >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.clrCnt) begin
      cnt <= '0;
    end else if (strobes.incCnt && (cnt < CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/temp_window_qual_ctl.sv
module temp_window_qual_ctl
  import temp_window_qual_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         msTick,
  input  logic         coldTrip,
  input  logic         coldRelease,
  input  logic         hotTrip,
  input  logic         cutTrip,
  input  logic         atLimit,
  output qualStrobes_t strobes,
  output logic         tempValid
);
  logic outOfRange;
  logic inRange;
  logic target;
  logic flip;

  // Leaving needs only the trip levels; re-entry on the cold side needs the release flag.
  assign outOfRange = coldTrip | hotTrip | cutTrip;
  assign inRange    = coldRelease & ~coldTrip & ~hotTrip & ~cutTrip;
  assign target     = tempValid ? outOfRange : inRange;
  assign flip       = target & msTick & atLimit;

  always_comb begin
    strobes.selLong = tempValid;
    strobes.clrCnt  = ~target | flip;
    strobes.incCnt  = target & msTick & ~atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempValid <= 1'b0;
    end else if (flip) begin
      tempValid <= ~tempValid;
    end
  end
endmodule

// File: rtl/temp_window_qual.sv
module temp_window_qual
  import temp_window_qual_pkg::*;
#(
  parameter int OUT_MS = 400,
  parameter int IN_MS  = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic coldTrip,
  input  logic coldRelease,
  input  logic hotTrip,
  input  logic cutTrip,
  output logic tempValid
);
  localparam int MAX_MS = (OUT_MS > IN_MS) ? OUT_MS : IN_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  qualStrobes_t     strobes;
  logic [CNT_W-1:0] cnt;
  logic             atLimit;

  temp_window_qual_ctl u_ctl (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .coldTrip(coldTrip), .coldRelease(coldRelease),
    .hotTrip(hotTrip), .cutTrip(cutTrip),
    .atLimit(atLimit), .strobes(strobes), .tempValid(tempValid)
  );

  temp_window_qual_dp #(.OUT_MS(OUT_MS), .IN_MS(IN_MS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cnt(cnt), .atLimit(atLimit)
  );
endmodule

// File: rtl/temp_window_qual_chk.sv
module temp_window_qual_chk #(
  parameter int OUT_MS = 400,
  parameter int IN_MS  = 20,
  parameter int CNT_W  = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             msTick,
  input logic             coldTrip,
  input logic             coldRelease,
  input logic             hotTrip,
  input logic             cutTrip,
  input logic             tempValid,
  input logic [CNT_W-1:0] cnt
);
  localparam int MAX_MS = (OUT_MS > IN_MS) ? OUT_MS : IN_MS;

  p_fall_needs_out_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tempValid) |-> $past(coldTrip | hotTrip | cutTrip));

  p_rise_needs_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tempValid) |-> $past(coldRelease & ~coldTrip & ~hotTrip & ~cutTrip));

  p_band_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tempValid && !coldTrip && !coldRelease) |=> !tempValid);

  p_break_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && !coldTrip && !hotTrip && !cutTrip) |=> (cnt == '0));

  p_change_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    !msTick |=> $stable(tempValid));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) <= MAX_MS - 1);
endmodule

bind temp_window_qual temp_window_qual_chk #(
  .OUT_MS(OUT_MS), .IN_MS(IN_MS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick),
  .coldTrip(coldTrip), .coldRelease(coldRelease),
  .hotTrip(hotTrip), .cutTrip(cutTrip),
  .tempValid(tempValid), .cnt(cnt)
);

// File: tb/temp_window_qual_bench.sv
module temp_window_qual_bench;
  localparam int OUT_MS = 12;
  localparam int IN_MS  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic coldTrip = 1'b0, coldRelease = 1'b0, hotTrip = 1'b0, cutTrip = 1'b0;
  logic tempValid;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  temp_window_qual #(.OUT_MS(OUT_MS), .IN_MS(IN_MS)) u_temp_window_qual (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .coldTrip(coldTrip), .coldRelease(coldRelease),
    .hotTrip(hotTrip), .cutTrip(cutTrip), .tempValid(tempValid)
  );

  // Vector: {coldTrip, coldRelease, hotTrip, cutTrip, ticks[4:0], expected, reqNum[3:0]}
  localparam int NV = 17;
  localparam bit [13:0] VEC [NV] = '{
    {4'b0100, 5'd3,  1'b0, 4'd5},  // R5 not yet after IN_MS-1
    {4'b0100, 5'd1,  1'b1, 4'd2},  // R2 rises on IN_MS-th tick
    {4'b1000, 5'd11, 1'b1, 4'd1},  // R1 cold, one short
    {4'b1000, 5'd1,  1'b0, 4'd1},  // R1 cold exit
    {4'b0000, 5'd10, 1'b0, 4'd3},  // R3 hysteresis band
    {4'b0100, 5'd4,  1'b1, 4'd2},  // R2 resume
    {4'b0010, 5'd11, 1'b1, 4'd1},  // R1 hot, one short
    {4'b0100, 5'd1,  1'b1, 4'd4},  // R4 glitch back in range
    {4'b0010, 5'd11, 1'b1, 4'd4},  // R4 count restarted
    {4'b0010, 5'd1,  1'b0, 4'd1},  // R1 hot exit
    {4'b0110, 5'd6,  1'b0, 4'd3},  // R3 release with hot does not count
    {4'b0100, 5'd4,  1'b1, 4'd2},  // R2 resume
    {4'b0001, 5'd12, 1'b0, 4'd1},  // R1 cutoff exit
    {4'b0100, 5'd3,  1'b0, 4'd4},  // R4 one short
    {4'b0001, 5'd1,  1'b0, 4'd4},  // R4 interruption
    {4'b0100, 5'd3,  1'b0, 4'd4},  // R4 restarted, still short
    {4'b0100, 5'd1,  1'b1, 4'd2}   // R2 completes
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (tempValid !== exp) begin
      errors++;
      $display("FAIL R%0d %s: tempValid actual %b expected %b", req, what, tempValid, exp);
    end
  endtask

  task automatic setFlags(input logic [3:0] f);
    {coldTrip, coldRelease, hotTrip, cutTrip} = f;
  endtask

  // One tick every four clocks; inputs change at negedge.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 5, "reset state");  // R5
    rstN = 1'b1;
    setFlags(4'b0100);
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      setFlags(VEC[v][13:10]);
      ticks(int'(VEC[v][9:5]));
      check(VEC[v][4], int'(VEC[v][3:0]), $sformatf("vector %0d", v));
    end
    // R6: out-of-range held for many clocks without ticks; no change
    setFlags(4'b0100);
    ticks(IN_MS);
    check(1'b1, 6, "valid before tickless hold");
    setFlags(4'b1000);
    repeat (200) @(negedge clk);
    check(1'b1, 6, "no tick, no change");
    // R5: reset mid-run forces invalid, then full requalification
    rstN = 1'b0;
    @(negedge clk);
    check(1'b0, 5, "reset mid-run");
    rstN = 1'b1;
    setFlags(4'b0100);
    ticks(IN_MS - 1);
    check(1'b0, 5, "requalify short after reset");
    ticks(1);
    check(1'b1, 5, "requalify done after reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule